// File: doc/BRIEF.md
# UART Interrupt and FIFO Watermark Unit

This block is the register-facing half of a serial port. It owns two 128-byte queues, one holding bytes waiting to be transmitted and one holding bytes already received, and it turns their fill levels into interrupt sources. Software writes transmit bytes and reads received bytes through a small register window at fixed offsets. The serial engine, which is outside this block, takes transmit bytes and delivers received bytes through single-cycle strobes. A third strobe reports a line break, and a bit-time tick drives the receive idle timer.

Four interrupt sources exist. Two of them are levels that follow the queue counts against programmable watermarks. Two are latches: the break latch and the receive-idle timeout latch. Each latch stays set until software writes a one to the matching bit of the clear register. An enable register masks the four sources. The masked result can be read back, and it is also ORed onto a single interrupt line.

Top module: `uart_irq_unit`

## Requirements
- R1: After reset the count register (0x0C) reads 0, the watermark register (0x20) reads 0x4040, control register 1 (0x1C) reads 0x3E00, the enable (0x10) and masked status (0x2C) registers read 0, and `irq` and `tx_avail` are low.
- R2: A write to offset 0x00 queues byte wdata[7:0] for transmit, and the transmit count in bits 15:8 of 0x0C goes up by one. `tx_byte` presents the oldest queued byte and `tx_pop` removes it. A write made while 128 bytes are queued is dropped.
- R3: A `rx_push` queues `rx_byte` for receive, and the receive count in bits 7:0 of 0x0C goes up by one. A read of offset 0x04 with `reg_re` returns the oldest byte and removes it. A push made while 128 bytes are queued is dropped. A read made while the queue is empty returns 0 and changes nothing.
- R4: The watermark register at 0x20 holds the receive watermark in bits 6:0 and the transmit watermark in bits 14:8. Its other bits read 0.
- R5: Source bit 0 (receive level) is 1 while the receive count is at or above the receive watermark. Source bit 1 (transmit level) is 1 while the transmit count is below the transmit watermark.
- R6: A `brk_stb` latches source bit 7. Only writing a 1 to bit 7 of the clear register at 0x14 clears it.
- R7: Bits 13:8 of 0x1C hold an idle limit N. Source bit 13 latches on the N-th `bit_tick` counted since the latest `rx_push`, while the receive queue is non-empty. Each push restarts the count, and an empty queue holds the count at zero.
- R8: Source bit 13 stays set after the receive queue drains and after writes of 1 to other clear bits. Only writing a 1 to bit 13 of 0x14 clears it.
- R9: The enable register at 0x10 keeps only bits 0, 1, 7 and 13. The masked status at 0x2C equals the source bits ANDed with the enable register.
- R10: `irq` is high exactly when the masked status is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 6 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops the receive queue at 0x04) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| tx_pop | input | 1 | Engine takes the byte on tx_byte |
| tx_byte | output | 8 | Oldest queued transmit byte |
| tx_avail | output | 1 | Transmit queue non-empty |
| rx_push | input | 1 | Engine delivers rx_byte |
| rx_byte | input | 8 | Received byte |
| brk_stb | input | 1 | Break seen on the line |
| bit_tick | input | 1 | One pulse per bit-time |
| irq | output | 1 | Interrupt request |

## Verification
The in-line properties check, on every cycle, that a queue count never passes 128 and stays put when a full queue receives a push or an empty queue receives a pop. They also check that a pushed byte restarts the idle counter, that a break strobe always sets its latch, that the timeout latch cannot drop without its own clear bit, and that the interrupt line never rises while the enable register is zero. The exact watermark comparisons at their edges, the byte order through both queues, the tick count at which the timeout fires, and the way masking interacts with latched state are only shown by the bench's scenarios.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam logic [5:0] A_TXD  = 6'h00;
  localparam logic [5:0] A_RXD  = 6'h04;
  localparam logic [5:0] A_CNT  = 6'h0C;
  localparam logic [5:0] A_IEN  = 6'h10;
  localparam logic [5:0] A_CLR  = 6'h14;
  localparam logic [5:0] A_CTL1 = 6'h1C;
  localparam logic [5:0] A_THR  = 6'h20;
  localparam logic [5:0] A_MSR  = 6'h2C;

  localparam int B_RXF  = 0;
  localparam int B_TXE  = 1;
  localparam int B_BRK  = 7;
  localparam int B_TOUT = 13;

  localparam logic [31:0] SRC_MASK =
    (32'd1 << B_RXF) | (32'd1 << B_TXE) | (32'd1 << B_BRK) | (32'd1 << B_TOUT);

  // receive-level rule: count has reached the watermark
  function automatic logic fill_reached(input int unsigned cnt, input int unsigned wm);
    return cnt >= wm;
  endfunction

  // transmit-level rule: count is strictly under the watermark
  function automatic logic drain_below(input int unsigned cnt, input int unsigned wm);
    return cnt < wm;
  endfunction

  function automatic logic [31:0] src_vector(input logic rxf, input logic txe,
                                             input logic brk, input logic tout);
    logic [31:0] v;
    v         = '0;
    v[B_RXF]  = rxf;
    v[B_TXE]  = txe;
    v[B_BRK]  = brk;
    v[B_TOUT] = tout;
    return v;
  endfunction
endpackage

// File: rtl/uif_fifo.sv
module uif_fifo #(
  parameter int DEPTH = 128,
  parameter int W     = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          full, do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= step(wp);
      if (do_pop)  rp <= step(rp);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  // R2 R3: occupancy bound
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R3: push into a full queue is dropped
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (count == CW'(DEPTH)));

  // R3: pop of an empty queue changes nothing
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);
endmodule

// File: rtl/uif_idle_timer.sv
module uif_idle_timer #(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          arrive,
  input  logic          pending,
  input  logic [TW-1:0] limit,
  output logic          fire
);
  logic [TW-1:0] idle_cnt;
  logic [TW:0]   next_cnt;

  assign next_cnt = {1'b0, idle_cnt} + (TW+1)'(1);
  assign fire     = tick && pending && !arrive && (next_cnt >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (!rst_n)                 idle_cnt <= '0;
    else if (arrive || !pending) idle_cnt <= '0;
    else if (tick && !fire)     idle_cnt <= next_cnt[TW-1:0];
  end

  // R7: a new byte restarts the idle count
  idle_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arrive |=> (idle_cnt == '0));
endmodule

// File: rtl/uif_irq_regs.sv
module uif_irq_regs
  import uart_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ien_we,
  input  logic        clr_we,
  input  logic [31:0] wdata,
  input  logic        brk_evt,
  input  logic        tout_evt,
  input  logic        rxf_lvl,
  input  logic        txe_lvl,
  output logic [31:0] ien_q,
  output logic [31:0] msr,
  output logic        irq
);
  logic        brk_lat, tout_lat;
  logic        clr_brk, clr_tout;
  logic [31:0] raw;

  assign clr_brk  = clr_we && wdata[B_BRK];
  assign clr_tout = clr_we && wdata[B_TOUT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q    <= '0;
      brk_lat  <= 1'b0;
      tout_lat <= 1'b0;
    end else begin
      if (ien_we) ien_q <= wdata & SRC_MASK;
      brk_lat  <= brk_evt  || (brk_lat  && !clr_brk);
      tout_lat <= tout_evt || (tout_lat && !clr_tout);
    end
  end

  assign raw = src_vector(rxf_lvl, txe_lvl, brk_lat, tout_lat);
  assign msr = raw & ien_q;
  assign irq = |msr;

  // R6
  brk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> brk_lat);

  // R8
  tout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tout_lat && !clr_tout) |=> tout_lat);

  // R10
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien_q != '0));
endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 128,
  parameter int TOUT_W     = 6,
  parameter int TOUT_RST   = 62,
  parameter int WM_RST     = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  reg_addr,
  input  logic        reg_we,
  input  logic        reg_re,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        tx_pop,
  output logic [7:0]  tx_byte,
  output logic        tx_avail,
  input  logic        rx_push,
  input  logic [7:0]  rx_byte,
  input  logic        brk_stb,
  input  logic        bit_tick,
  output logic        irq
);
  localparam int CW   = $clog2(FIFO_DEPTH + 1);
  localparam int WM_W = $clog2(FIFO_DEPTH);

  logic [CW-1:0]     rx_cnt, tx_cnt;
  logic [7:0]        rx_dout;
  logic              rx_empty, tx_empty;
  logic [WM_W-1:0]   rx_wm, tx_wm;
  logic [TOUT_W-1:0] tout_lim;
  logic              tx_wr, rx_rd, rxf_lvl, txe_lvl, tout_evt;
  logic [31:0]       ien_q, msr;

  assign tx_wr = reg_we && (reg_addr == A_TXD);
  assign rx_rd = reg_re && (reg_addr == A_RXD);

  uif_fifo #(.DEPTH(FIFO_DEPTH), .W(8), .CW(CW)) u_txq (
    .clk, .rst_n, .push(tx_wr), .din(reg_wdata[7:0]), .pop(tx_pop),
    .dout(tx_byte), .count(tx_cnt), .empty(tx_empty));

  uif_fifo #(.DEPTH(FIFO_DEPTH), .W(8), .CW(CW)) u_rxq (
    .clk, .rst_n, .push(rx_push), .din(rx_byte), .pop(rx_rd),
    .dout(rx_dout), .count(rx_cnt), .empty(rx_empty));

  assign tx_avail = !tx_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_wm    <= WM_W'(WM_RST);
      tx_wm    <= WM_W'(WM_RST);
      tout_lim <= TOUT_W'(TOUT_RST);
    end else if (reg_we) begin
      if (reg_addr == A_THR) begin
        rx_wm <= reg_wdata[WM_W-1:0];
        tx_wm <= reg_wdata[8 +: WM_W];
      end
      if (reg_addr == A_CTL1) tout_lim <= reg_wdata[8 +: TOUT_W];
    end
  end

  assign rxf_lvl = fill_reached(32'(rx_cnt), 32'(rx_wm));
  assign txe_lvl = drain_below(32'(tx_cnt), 32'(tx_wm));

  uif_idle_timer #(.TW(TOUT_W)) u_idle (
    .clk, .rst_n, .tick(bit_tick), .arrive(rx_push), .pending(!rx_empty),
    .limit(tout_lim), .fire(tout_evt));

  uif_irq_regs u_irq (
    .clk, .rst_n,
    .ien_we(reg_we && (reg_addr == A_IEN)),
    .clr_we(reg_we && (reg_addr == A_CLR)),
    .wdata(reg_wdata), .brk_evt(brk_stb), .tout_evt(tout_evt),
    .rxf_lvl(rxf_lvl), .txe_lvl(txe_lvl),
    .ien_q(ien_q), .msr(msr), .irq(irq));

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_RXD:  reg_rdata = rx_empty ? 32'd0 : {24'd0, rx_dout};
      A_CNT:  reg_rdata = {16'd0, 8'(tx_cnt), 8'(rx_cnt)};
      A_IEN:  reg_rdata = ien_q;
      A_CTL1: reg_rdata = 32'(tout_lim) << 8;
      A_THR:  reg_rdata = (32'(tx_wm) << 8) | 32'(rx_wm);
      A_MSR:  reg_rdata = msr;
      default: reg_rdata = '0;
    endcase
  end

  // R2: no transmit byte offered while the queue is empty
  tx_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt == '0) |-> !tx_avail);
endmodule

// File: tb/sim_uart_irq_unit.sv
module sim_uart_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_pop = 1'b0;
  logic [7:0]  tx_byte;
  logic        tx_avail;
  logic        rx_push = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        brk_stb = 1'b0, bit_tick = 1'b0;
  logic        irq;

  int total = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_irq_unit u0 (.*);

  // {rx pushes, tx writes, rx watermark, tx watermark, enable}
  localparam logic [47:0] VECS [7] = '{
    {8'd0,   8'd0,   8'd64,  8'd64,  16'h0003},
    {8'd64,  8'd0,   8'd64,  8'd64,  16'h0003},
    {8'd63,  8'd64,  8'd64,  8'd64,  16'h0003},
    {8'd5,   8'd3,   8'd5,   8'd3,   16'h0001},
    {8'd128, 8'd127, 8'd127, 8'd127, 16'h0003},
    {8'd2,   8'd0,   8'd1,   8'd1,   16'h0000},
    {8'd10,  8'd2,   8'd20,  8'd4,   16'h0002}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); #1 reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic pop_rx(output logic [31:0] d);
    @(negedge clk); reg_addr = 6'h04; reg_re = 1'b1; #1 d = reg_rdata;
    @(posedge clk); #1 reg_re = 1'b0;
  endtask

  task automatic push_rx(input logic [7:0] b);
    @(negedge clk); rx_byte = b; rx_push = 1'b1;
    @(posedge clk); #1 rx_push = 1'b0;
  endtask

  task automatic pop_tx(output logic [7:0] b);
    @(negedge clk); b = tx_byte; tx_pop = 1'b1;
    @(posedge clk); #1 tx_pop = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); bit_tick = 1'b1;
    @(posedge clk); #1 bit_tick = 1'b0;
  endtask

  task automatic drain();
    logic [31:0] c, d;
    logic [7:0]  b;
    rd(6'h0C, c);
    for (int k = 0; k < int'(c[7:0]); k++) pop_rx(d);
    for (int k = 0; k < int'(c[15:8]); k++) pop_tx(b);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: act=running exp=finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d, expm;
    logic [7:0]  b;
    int rxn, txn, rwm, twm;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(6'h0C, d); check("R1 count", d, 32'h0);
    rd(6'h20, d); check("R1 watermarks", d, 32'h4040);
    rd(6'h1C, d); check("R1 ctl1", d, 32'h3E00);
    rd(6'h10, d); check("R1 enable", d, 32'h0);
    rd(6'h2C, d); check("R1 status", d, 32'h0);
    check("R1 irq/tx_avail", {30'd0, irq, tx_avail}, 32'h0);

    // R9 enable keeps only defined bits
    wr(6'h10, 32'hFFFF_FFFF);
    rd(6'h10, d); check("R9 enable mask", d, 32'h2083);
    wr(6'h10, 32'h0);

    // R4 R5 R9 table walk
    for (int i = 0; i < 7; i++) begin
      drain();
      rxn = int'(VECS[i][47:40]); txn = int'(VECS[i][39:32]);
      rwm = int'(VECS[i][31:24]); twm = int'(VECS[i][23:16]);
      wr(6'h20, 32'((twm << 8) | rwm));
      rd(6'h20, d); check("R4 watermark readback", d, 32'((twm << 8) | rwm));
      for (int k = 0; k < rxn; k++) push_rx(8'(k));
      for (int k = 0; k < txn; k++) wr(6'h00, 32'(k));
      wr(6'h10, {16'd0, VECS[i][15:0]});
      expm = 32'(((rxn >= rwm) ? 1 : 0) | ((txn < twm) ? 2 : 0)) & {16'd0, VECS[i][15:0]};
      rd(6'h0C, d); check("R2 R3 counts", d, 32'((txn << 8) | rxn));
      rd(6'h2C, d); check("R5 R9 status", d, expm);
      check("R10 irq", {31'd0, irq}, {31'd0, expm != 0});
    end
    drain();
    wr(6'h10, 32'h0);
    wr(6'h20, 32'h4040);

    // R2 overflow and order
    for (int k = 0; k < 130; k++) wr(6'h00, 32'(k + 8'h10));
    rd(6'h0C, d); check("R2 tx full drop", d, 32'h8000);
    pop_tx(b); check("R2 tx first", {24'd0, b}, 32'h10);
    pop_tx(b); check("R2 tx second", {24'd0, b}, 32'h11);
    drain();
    check("R2 tx_avail low", {31'd0, tx_avail}, 32'h0);

    // R3 overflow, order, empty read
    for (int k = 0; k < 129; k++) push_rx(8'hA0 ^ 8'(k));
    rd(6'h0C, d); check("R3 rx full drop", d, 32'h0080);
    drain();
    push_rx(8'hA1); push_rx(8'hB2); push_rx(8'hC3);
    pop_rx(d); check("R3 rx order 1", d, 32'hA1);
    pop_rx(d); check("R3 rx order 2", d, 32'hB2);
    pop_rx(d); check("R3 rx order 3", d, 32'hC3);
    pop_rx(d); check("R3 empty read", d, 32'h0);
    rd(6'h0C, d); check("R3 empty count", d, 32'h0);

    // R6 break latch
    @(negedge clk); brk_stb = 1'b1; @(posedge clk); #1 brk_stb = 1'b0;
    rd(6'h2C, d); check("R6 break masked off", d, 32'h0);
    check("R10 irq masked", {31'd0, irq}, 32'h0);
    wr(6'h10, 32'h80);
    rd(6'h2C, d); check("R6 break latched", d, 32'h80);
    check("R10 irq break", {31'd0, irq}, 32'h1);
    wr(6'h14, 32'h2000);
    rd(6'h2C, d); check("R6 other clear bit", d, 32'h80);
    wr(6'h14, 32'h80);
    rd(6'h2C, d); check("R6 break cleared", d, 32'h0);

    // R7 R8 timeout
    wr(6'h10, 32'h2000);
    wr(6'h1C, 32'h0400);
    rd(6'h1C, d); check("R7 limit readback", d, 32'h0400);
    tick(); tick();
    rd(6'h2C, d); check("R7 empty queue no timeout", d, 32'h0);
    push_rx(8'h55);
    tick(); tick(); tick();
    rd(6'h2C, d); check("R7 before limit", d, 32'h0);
    tick();
    rd(6'h2C, d); check("R7 at limit", d, 32'h2000);
    pop_rx(d);
    rd(6'h2C, d); check("R8 held after drain", d, 32'h2000);
    wr(6'h14, 32'h0080);
    rd(6'h2C, d); check("R8 held after other clear", d, 32'h2000);
    wr(6'h14, 32'h2000);
    rd(6'h2C, d); check("R8 cleared", d, 32'h0);
    push_rx(8'h01);
    tick(); tick(); tick();
    push_rx(8'h02);
    tick(); tick(); tick();
    rd(6'h2C, d); check("R7 push restarts", d, 32'h0);
    tick();
    rd(6'h2C, d); check("R7 fires after restart", d, 32'h2000);
    check("R10 irq timeout", {31'd0, irq}, 32'h1);

    done = 1;
    finish_run();
  end
endmodule